// File: doc/BRIEF.md
# Memory Test Traffic Generator

This block produces a stream of read and write requests toward a memory user interface, so that a memory can be exercised at full clock rate without help from software. Software first programs a small set of configuration registers: the read/write interleave, the address pattern, the data pattern, the step sizes, an address window and a request count. A start pulse then launches a run. The generator presents one request per clock on a valid/ready channel. Each request carries a command bit, an address, write data and a 4-bit transaction ID. When the programmed number of requests has been accepted, the generator raises a done flag.

The address and data values come from two independent pattern engines. Each engine can hold a constant, step up or down by a programmed amount, walk a single zero or a single one across the word, alternate checkerboard words, or run a Galois LFSR. The data LFSR can be frozen one byte lane at a time, so that lanes which are not used do not toggle. A directed mode replaces the patterns with one to four transactions that the user writes in explicitly.

Configuration register map, selected by `cfg_sel`:

| Select | Content |
|---|---|
| 0 | control word |
| 1 | address base / seed |
| 2 | address step |
| 3 | address window |
| 4 | data seed |
| 5 | data step |
| 6 | request count |
| 7 | lane enables |
| 8..11 | directed addresses 0..3 |
| 12..15 | directed data 0..3 |

Control word fields:

| Bits | Field |
|---|---|
| [1:0] | interleave |
| [4:2] | address pattern |
| [7:5] | data pattern |
| [8] | directed |
| [10:9] | number of directed slots minus one |
| [14:11] | per-slot read flags |

Top module: `mtg_top`

## Requirements
- R1: After reset, req_valid, busy and done are all low.
- R2: The interleave field selects the command of request n (counted from 0 in each run): 0 gives all writes, 1 gives all reads, 2 gives a write when n is even and a read when n is odd, and 3 gives a write when bit 1 of n is 0 and a read otherwise (W W R R repeating). req_write is 1 for a write.
- R3: The pattern codes 0 (constant), 1 (increment) and 2 (decrement) work as follows. The address of request n is base, base+off or base+off respectively, where off = (n*step) mod window for increment and off = (window - (n*step) mod window) mod window for decrement. A window of 0 means arithmetic modulo 2^ADDR_W, and the step must be smaller than a nonzero window. For data, the same codes give seed, seed+j*step or seed-j*step modulo 2^DATA_W, where j counts the writes issued before this one.
- R4: Code 4 gives a word with a single 0 at bit k, code 5 gives a word with a single 1 at bit k, and code 6 gives 0xAAAA... when k is even and 0x5555... when k is odd. Here k is the request index n for the address and the write index j for the data, taken modulo the word width.
- R5: Code 3 outputs a right-shifting Galois LFSR with tap mask 0x80200003 at the default width. The LFSR is loaded from the base or seed at start, and a seed of 0 loads 1. It steps once per accepted request for the address and once per accepted write for the data.
- R6: At each data LFSR step, byte lane b (bits 8b+7..8b) takes its next value only if lane-enable bit b is 1; otherwise the lane keeps its previous value.
- R7: The data engine advances only on accepted writes, and a read request carries write data 0.
- R8: While req_valid is high and req_ready is low, every request field stays unchanged and no pattern advances.
- R9: req_id is 0 for the first request of a run and increases by one per accepted request, wrapping from 15 to 0.
- R10: A run ends exactly after the programmed count of requests has been accepted. req_valid drops and done rises on the edge that follows the last acceptance. A start with a count of 0 sets done without issuing any request.
- R11: In directed mode, slots 0 through the programmed last slot are issued in order. Each slot uses its own address and data registers, and it is a read when its read flag is set.
- R12: With req_ready held high, a new request is presented on every clock until the run ends.
- R13: While busy is high, a start pulse and configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write value |
| start | input | 1 | Launches a run when idle |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | The memory interface accepts the request |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Write data (0 on reads) |
| req_id | output | 4 | Transaction ID |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |

## Verification
When start is sampled at a rising edge, the first request appears on the ports right after that same edge. Each acceptance moves the request fields to the next value on the following edge, and done rises on the edge after the last acceptance. The bench therefore drives its inputs at falling edges and samples at falling edges. It compares the request present at each falling edge with the model's request at the current index, and advances that index only when it has driven ready high for the coming edge. A stalled cycle is compared against the previous cycle's fields, and after each run the number of accepted requests is compared with the count that was programmed.

// File: rtl/mtg_pkg.sv
// Shared types and constants for the memory test traffic generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mtg_pkg;

    typedef enum logic [1:0] {
        OP_WRITES = 2'd0,
        OP_READS  = 2'd1,
        OP_ALT1   = 2'd2,
        OP_ALT2   = 2'd3
    } op_mode_e;

    typedef enum logic [2:0] {
        PAT_CONST   = 3'd0,
        PAT_INC     = 3'd1,
        PAT_DEC     = 3'd2,
        PAT_RAND    = 3'd3,
        PAT_WALK0   = 3'd4,
        PAT_WALK1   = 3'd5,
        PAT_CHECKER = 3'd6,
        PAT_SPARE   = 3'd7
    } pat_e;

    localparam int ID_W      = 4;
    localparam int DIR_SLOTS = 4;
    localparam int SEL_W     = 4;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_ABASE = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ASTEP = 4'd2;
    localparam logic [SEL_W-1:0] SEL_AWIN  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_DSEED = 4'd4;
    localparam logic [SEL_W-1:0] SEL_DSTEP = 4'd5;
    localparam logic [SEL_W-1:0] SEL_COUNT = 4'd6;
    localparam logic [SEL_W-1:0] SEL_LANES = 4'd7;

    // Right-shift Galois tap masks of maximal length for common widths.
    function automatic logic [63:0] galois_mask(input int w);
        case (w)
            8:       return 64'h0000_0000_0000_00B8;
            16:      return 64'h0000_0000_0000_B400;
            24:      return 64'h0000_0000_00E1_0000;
            32:      return 64'h0000_0000_8020_0003;
            64:      return 64'hD800_0000_0000_0000;
            default: return (64'h1 << (w - 1)) | 64'h3;
        endcase
    endfunction

endpackage

// File: rtl/mtg_lfsr.sv
// Galois LFSR with per-byte-lane stepping.
// On load the register takes the seed (a zero seed becomes 1). On adv each
// byte lane whose enable bit is set takes its next value, and each other lane
// holds its bits. Assumes W is a multiple of 8.
module mtg_lfsr import mtg_pkg::*; #(
    parameter int W     = 32,
    parameter int LANES = W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [W-1:0]     seed,
    input  logic [LANES-1:0] lane_en,
    output logic [W-1:0]     state
);
    localparam logic [W-1:0] TAPS = W'(galois_mask(W));

    logic [W-1:0] shifted;
    logic [W-1:0] gated;

    // One Galois step: shift right, fold the taps in when the bit shifted out is 1.
    always_comb begin
        shifted = (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // Each byte lane selects its stepped or held value.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign gated[8*b +: 8] = lane_en[b] ? shifted[8*b +: 8] : state[8*b +: 8];
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W'(1);
        end else if (load) begin
            state <= (seed == '0) ? W'(1) : seed;
        end else if (adv) begin
            state <= gated;
        end
    end

endmodule

// File: rtl/mtg_pattern.sv
// One pattern engine, used for either the address or the data.
// Holds an offset, a walk index, a checkerboard phase and an LFSR. It moves
// them on every adv, and its output is a combinational function of that state.
// Assumes the pattern select is stable between load and the end of the run,
// and that step < window whenever the window is nonzero.
module mtg_pattern import mtg_pkg::*; #(
    parameter int W     = 32,
    parameter int LANES = W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  pat_e             pat,
    input  logic [W-1:0]     base,
    input  logic [W-1:0]     step,
    input  logic [W-1:0]     window,
    input  logic [LANES-1:0] lane_en,
    output logic [W-1:0]     value
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);
    localparam logic [W-1:0] CHK_A = {(W/2){2'b10}};

    logic [W-1:0]     off;
    logic [IDX_W-1:0] idx;
    logic             phase;
    logic [W-1:0]     rnd;
    logic [W:0]       sum_up;
    logic [W-1:0]     off_up;
    logic [W-1:0]     off_dn;
    logic [W-1:0]     onehot;

    // Next offset for the increment and decrement patterns, wrapped into the window.
    always_comb begin
        sum_up = {1'b0, off} + {1'b0, step};
        if (window != '0 && sum_up >= {1'b0, window}) begin
            off_up = W'(sum_up - {1'b0, window});
        end else begin
            off_up = sum_up[W-1:0];
        end
        if (window == '0 || off >= step) begin
            off_dn = off - step;
        end else begin
            off_dn = off + window - step;
        end
    end

    // Offset, walk index and checkerboard phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off   <= '0;
            idx   <= '0;
            phase <= 1'b0;
        end else if (load) begin
            off   <= '0;
            idx   <= '0;
            phase <= 1'b0;
        end else if (adv) begin
            case (pat)
                PAT_INC: off <= off_up;
                PAT_DEC: off <= off_dn;
                default: off <= off;
            endcase
            idx   <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
            phase <= ~phase;
        end
    end

    mtg_lfsr #(.W(W), .LANES(LANES)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv && (pat == PAT_RAND)),
        .seed    (base),
        .lane_en (lane_en),
        .state   (rnd)
    );

    // Output word selected by the pattern code.
    always_comb begin
        onehot = W'(1) << idx;
        case (pat)
            PAT_INC,
            PAT_DEC:     value = base + off;
            PAT_RAND:    value = rnd;
            PAT_WALK0:   value = ~onehot;
            PAT_WALK1:   value = onehot;
            PAT_CHECKER: value = phase ? ~CHK_A : CHK_A;
            default:     value = base;
        endcase
    end

endmodule

// File: rtl/mtg_seq.sv
// Run sequencer: counts accepted requests, chooses each request's command
// and ID, and owns the busy and done flags. The request is valid for the whole
// time busy is high, so with ready held high one request is accepted per clock.
// Assumes CNT_W >= 3.
module mtg_seq import mtg_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ready,
    input  op_mode_e             op,
    input  logic                 directed,
    input  logic [1:0]           dir_last,
    input  logic [DIR_SLOTS-1:0] dir_rd,
    input  logic [CNT_W-1:0]     count,
    output logic                 valid,
    output logic                 write,
    output logic                 hs,
    output logic                 launch,
    output logic [1:0]           slot,
    output logic [ID_W-1:0]      id,
    output logic                 busy,
    output logic                 done
);
    logic [CNT_W-1:0] issued;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] issued_nx;

    // Run length, launch and handshake qualifiers.
    always_comb begin
        total     = directed ? ({{(CNT_W-2){1'b0}}, dir_last} + 1'b1) : count;
        launch    = start && !busy;
        valid     = busy;
        hs        = busy && ready;
        issued_nx = issued + 1'b1;
        slot      = issued[1:0];
    end

    // Command of the current request from the interleave or the directed slot flags.
    always_comb begin
        if (directed) begin
            write = !dir_rd[issued[1:0]];
        end else begin
            case (op)
                OP_WRITES: write = 1'b1;
                OP_READS:  write = 1'b0;
                OP_ALT1:   write = !issued[0];
                default:   write = !issued[1];
            endcase
        end
    end

    // Run state: busy/done flags, request count and transaction ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            issued <= '0;
            id     <= '0;
        end else if (launch) begin
            issued <= '0;
            id     <= '0;
            busy   <= (total != '0);
            done   <= (total == '0);
        end else if (hs) begin
            issued <= issued_nx;
            id     <= id + 1'b1;
            if (issued_nx == total) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtg_top.sv
// Memory test traffic generator top level.
// Holds the configuration registers (writable only while idle), and combines
// the run sequencer with the address and data pattern engines. It drives a
// valid/ready request channel. Assumes ADDR_W and DATA_W are multiples of 8,
// and that CNT_W and the lane count fit in the configuration word.
module mtg_top import mtg_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int CFG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int LANES = DATA_W / 8,
    localparam int ALANE = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [ID_W-1:0]   req_id,
    output logic              busy,
    output logic              done
);
    logic [14:0]       ctrl;
    logic [ADDR_W-1:0] abase, astep, awin;
    logic [DATA_W-1:0] dseed, dstep;
    logic [CNT_W-1:0]  count;
    logic [LANES-1:0]  lanes;
    logic [ADDR_W-1:0] dir_addr [DIR_SLOTS];
    logic [DATA_W-1:0] dir_data [DIR_SLOTS];

    op_mode_e             op;
    pat_e                 apat, dpat;
    logic                 directed;
    logic [1:0]           dir_last;
    logic [DIR_SLOTS-1:0] dir_rd;

    logic              hs, launch, wr;
    logic [1:0]        slot;
    logic [ADDR_W-1:0] aval;
    logic [DATA_W-1:0] dval;

    // Configuration register file, written only while no run is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            abase <= '0;
            astep <= '0;
            awin  <= '0;
            dseed <= '0;
            dstep <= '0;
            count <= '0;
            lanes <= '1;
            for (int i = 0; i < DIR_SLOTS; i++) begin
                dir_addr[i] <= '0;
                dir_data[i] <= '0;
            end
        end else if (cfg_wr && !busy) begin
            case (cfg_sel)
                SEL_CTRL:  ctrl  <= cfg_wdata[14:0];
                SEL_ABASE: abase <= cfg_wdata[ADDR_W-1:0];
                SEL_ASTEP: astep <= cfg_wdata[ADDR_W-1:0];
                SEL_AWIN:  awin  <= cfg_wdata[ADDR_W-1:0];
                SEL_DSEED: dseed <= cfg_wdata[DATA_W-1:0];
                SEL_DSTEP: dstep <= cfg_wdata[DATA_W-1:0];
                SEL_COUNT: count <= cfg_wdata[CNT_W-1:0];
                SEL_LANES: lanes <= cfg_wdata[LANES-1:0];
                default: begin
                    if (cfg_sel[3]) begin
                        if (cfg_sel[2]) dir_data[cfg_sel[1:0]] <= cfg_wdata[DATA_W-1:0];
                        else            dir_addr[cfg_sel[1:0]] <= cfg_wdata[ADDR_W-1:0];
                    end
                end
            endcase
        end
    end

    // Control word field decode.
    always_comb begin
        op       = op_mode_e'(ctrl[1:0]);
        apat     = pat_e'(ctrl[4:2]);
        dpat     = pat_e'(ctrl[7:5]);
        directed = ctrl[8];
        dir_last = ctrl[10:9];
        dir_rd   = ctrl[14:11];
    end

    mtg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ready    (req_ready),
        .op       (op),
        .directed (directed),
        .dir_last (dir_last),
        .dir_rd   (dir_rd),
        .count    (count),
        .valid    (req_valid),
        .write    (wr),
        .hs       (hs),
        .launch   (launch),
        .slot     (slot),
        .id       (req_id),
        .busy     (busy),
        .done     (done)
    );

    mtg_pattern #(.W(ADDR_W), .LANES(ALANE)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .adv     (hs && !directed),
        .pat     (apat),
        .base    (abase),
        .step    (astep),
        .window  (awin),
        .lane_en ({ALANE{1'b1}}),
        .value   (aval)
    );

    mtg_pattern #(.W(DATA_W), .LANES(LANES)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .adv     (hs && wr && !directed),
        .pat     (dpat),
        .base    (dseed),
        .step    (dstep),
        .window  ('0),
        .lane_en (lanes),
        .value   (dval)
    );

    // Request fields: directed slots override the pattern engines; reads carry zero data.
    always_comb begin
        req_write = wr;
        req_addr  = directed ? dir_addr[slot] : aval;
        if (!wr)           req_wdata = '0;
        else if (directed) req_wdata = dir_data[slot];
        else               req_wdata = dval;
    end

endmodule

// File: rtl/mtg_chk.sv
// Protocol checker for mtg_top, attached through bind. It observes the
// request channel and the run flags only.
module mtg_chk import mtg_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [ID_W-1:0]   req_id,
    input logic              busy,
    input logic              done
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                    && $stable(req_write) && $stable(req_id));

    // R9
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> req_id == $past(req_id) + 4'd1);

    // R7
    read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> req_wdata == '0);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !busy);

    // R13
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !req_ready |=> busy && $stable(req_id));

endmodule

bind mtg_top mtg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_id    (req_id),
    .busy      (busy),
    .done      (done)
);

// File: tb/mtg_top_test.sv
// Self-checking bench for mtg_top: directed runs with random ready stalls.
module mtg_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid, req_write, busy, done;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_id;

    int errors = 0;
    int checks = 0;

    // bench copies of the programmed configuration
    int          c_op, c_ap, c_dp, c_dir, c_last;
    logic [3:0]  c_rd, c_lanes;
    logic [31:0] c_abase, c_astep, c_awin, c_dseed, c_dstep;
    int          c_count;
    logic [31:0] c_daddr [4];
    logic [31:0] c_ddata [4];
    string       dtag_force;

    always #5 clk = ~clk;

    mtg_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_id(req_id), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] gstep(input logic [31:0] s, input logic [3:0] en);
        logic [31:0] n;
        n = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
        for (int b = 0; b < 4; b++) if (!en[b]) n[8*b +: 8] = s[8*b +: 8];
        return n;
    endfunction

    function automatic logic [31:0] patval(input int p, input logic [31:0] base,
            input logic [31:0] step, input logic [31:0] win, input int k,
            input logic [31:0] lf);
        longint unsigned prod;
        logic [31:0] o;
        prod = longint'(k) * longint'(step);
        case (p)
            1: begin
                o = (win != 0) ? 32'(prod % longint'(win)) : 32'(prod);
                return base + o;
            end
            2: begin
                o = (win != 0) ? 32'((longint'(win) - prod % longint'(win)) % longint'(win))
                               : 32'(-prod);
                return base + o;
            end
            3: return lf;
            4: return ~(32'h1 << (k % 32));
            5: return 32'h1 << (k % 32);
            6: return (k % 2 == 0) ? 32'hAAAA_AAAA : 32'h5555_5555;
            default: return base;
        endcase
    endfunction

    function automatic string ptag(input int p);
        if (p == 3) return "R5";
        if (p >= 4 && p <= 6) return "R4";
        return "R3";
    endfunction

    function automatic bit exp_write(input int n);
        if (c_dir != 0) return !c_rd[n % 4];
        case (c_op)
            0: return 1'b1;
            1: return 1'b0;
            2: return (n % 2) == 0;
            default: return ((n / 2) % 2) == 0;
        endcase
    endfunction

    task automatic wcfg(input int sel, input logic [31:0] val);
        cfg_wr = 1'b1; cfg_sel = 4'(sel); cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic setup(input int op, input int ap, input int dp,
                         input logic [31:0] abase, input logic [31:0] astep,
                         input logic [31:0] awin, input logic [31:0] dseed,
                         input logic [31:0] dstep, input int count,
                         input logic [3:0] lanes);
        c_op = op; c_ap = ap; c_dp = dp; c_dir = 0; c_last = 0; c_rd = 0;
        c_abase = abase; c_astep = astep; c_awin = awin; c_dseed = dseed;
        c_dstep = dstep; c_count = count; c_lanes = lanes;
        wcfg(0, 32'(op) | (32'(ap) << 2) | (32'(dp) << 5));
        wcfg(1, abase); wcfg(2, astep); wcfg(3, awin);
        wcfg(4, dseed); wcfg(5, dstep); wcfg(6, 32'(count)); wcfg(7, {28'h0, lanes});
    endtask

    task automatic setup_dir(input int last, input logic [3:0] rd);
        c_dir = 1; c_last = last; c_rd = rd;
        for (int i = 0; i < 4; i++) begin
            c_daddr[i] = 32'h0000_A000 + 32'(i) * 32'h44;
            c_ddata[i] = 32'h1234_0000 ^ (32'(i) * 32'h0101_0101);
            wcfg(8 + i, c_daddr[i]);
            wcfg(12 + i, c_ddata[i]);
        end
        wcfg(0, 32'h100 | (32'(last) << 9) | (32'(rd) << 11));
    endtask

    // Launch one run and check every request against the model.
    task automatic run(input int rdy_pct, input bit poke);
        int n, wi, total, guard;
        bit prev_hs, prev_stall, poked, wr, hs;
        logic [31:0] alf, dlf, ea, ed, pa, pd;
        string at, dt;
        total = (c_dir != 0) ? c_last + 1 : c_count;
        alf = (c_abase == 0) ? 32'h1 : c_abase;
        dlf = (c_dseed == 0) ? 32'h1 : c_dseed;
        n = 0; wi = 0; prev_hs = 0; prev_stall = 0; poked = 0; guard = 0;
        pa = 0; pd = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (guard < 5000) begin
            guard++;
            if (prev_hs && n < total)
                chk(req_valid == 1'b1, "R12", "back-to-back valid", 64'(req_valid), 64'h1);
            if (!req_valid) break;
            wr = exp_write(n);
            ea = (c_dir != 0) ? c_daddr[n % 4] : patval(c_ap, c_abase, c_astep, c_awin, n, alf);
            ed = !wr ? 32'h0 : (c_dir != 0) ? c_ddata[n % 4]
                             : patval(c_dp, c_dseed, c_dstep, 32'h0, wi, dlf);
            at = (c_dir != 0) ? "R11" : ptag(c_ap);
            if (c_dir != 0)                      dt = "R11";
            else if (!wr)                        dt = "R7";
            else if (dtag_force != "")           dt = dtag_force;
            else if (c_dp == 3 && c_lanes != 4'hF) dt = "R6";
            else                                 dt = ptag(c_dp);
            chk(req_write == wr, (c_dir != 0) ? "R11" : "R2", "command", 64'(req_write), 64'(wr));
            chk(req_addr == ea, at, "address", 64'(req_addr), 64'(ea));
            chk(req_wdata == ed, dt, "write data", 64'(req_wdata), 64'(ed));
            chk(req_id == 4'(n), "R9", "id", 64'(req_id), 64'(n % 16));
            if (prev_stall)
                chk(req_addr == pa && req_wdata == pd, "R8", "held over stall",
                    {req_addr, req_wdata}, {pa, pd});
            pa = req_addr; pd = req_wdata;
            hs = (rdy_pct >= 100) ? 1'b1 : (($urandom % 100) < rdy_pct);
            req_ready = hs;
            if (poke && !poked && n == 3) begin
                poked = 1;
                start = 1'b1;
                cfg_wr = 1'b1; cfg_sel = 4'd6; cfg_wdata = 32'd5;
            end
            if (hs) begin
                if (c_dir == 0 && c_ap == 3) alf = gstep(alf, 4'hF);
                if (c_dir == 0 && wr) begin
                    if (c_dp == 3) dlf = gstep(dlf, c_lanes);
                    wi++;
                end
                n++;
            end
            prev_hs = hs; prev_stall = !hs;
            @(negedge clk);
            start = 1'b0; cfg_wr = 1'b0;
        end
        req_ready = 1'b0;
        chk(n == total, poke ? "R13" : "R10", "accepted count", 64'(n), 64'(total));
        chk(done == 1'b1 && busy == 1'b0, "R10", "done after run",
            {62'h0, done, busy}, 64'h2);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        dtag_force = "";
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_valid == 0 && busy == 0 && done == 0, "R1", "reset flags",
            {61'h0, req_valid, busy, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 0 && busy == 0 && done == 0, "R1", "idle after reset",
            {61'h0, req_valid, busy, done}, 64'h0);

        // writes, incrementing address with window wrap, constant data
        setup(0, 1, 0, 32'h1000, 32'd4, 32'h40, 32'hDEAD_BEEF, 32'd0, 24, 4'hF);
        run(100, 0);
        // reads, decrementing address in a window of 10
        setup(1, 2, 1, 32'h200, 32'd3, 32'd10, 32'h0, 32'd1, 20, 4'hF);
        run(50, 0);
        // alternating, random address and data, zero data seed
        setup(2, 3, 3, 32'h1234_5678, 32'd0, 32'd0, 32'h0, 32'd0, 30, 4'hF);
        run(60, 0);
        // paired alternation, walking one / walking zero, ID wrap
        setup(3, 5, 4, 32'h0, 32'd0, 32'd0, 32'h0, 32'd0, 40, 4'hF);
        run(80, 0);
        // checkerboard address, random data with lanes 0 and 2 only
        setup(0, 6, 3, 32'h0, 32'd0, 32'd0, 32'hCAFE_F00D, 32'd0, 20, 4'h5);
        run(70, 0);
        // data steps only on writes; start and count write while busy
        dtag_force = "R7";
        setup(2, 0, 1, 32'h0000_0F00, 32'd0, 32'd0, 32'd100, 32'd7, 12, 4'hF);
        run(70, 1);
        dtag_force = "";
        // decrement data over full range with walking-zero address
        setup(0, 4, 2, 32'h0, 32'd0, 32'd0, 32'd5, 32'd3, 36, 4'hF);
        run(100, 0);

        // count of zero
        setup(0, 0, 0, 32'h0, 32'd0, 32'd0, 32'h0, 32'd0, 0, 4'hF);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && req_valid == 1'b0 && busy == 1'b0, "R10", "zero count",
            {61'h0, done, req_valid, busy}, 64'h4);
        @(negedge clk);

        // directed single and four-slot runs
        setup_dir(0, 4'b0000);
        run(100, 0);
        setup_dir(3, 4'b1010);
        run(50, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule